// File: doc/BRIEF.md
# Delayed-Parity Command Error Checker

This block watches a 22-bit address/command bus whose even-parity bit is sent one clock after the bits it covers. On each rising edge it records the parity of the bus and whether the command was valid, meaning at least one of four active-low chip selects was low. On the next edge it compares that stored parity with the late parity bit. A mismatch on a valid command is reported one clock after the comparison. The report is an active-low error flag that stays asserted for two cycles.

The flag models an open-drain pin. One output is the pull-down enable. The other is the resolved pin level, which reads high whenever nothing pulls it down. The active-low reset is asynchronous. It releases the pin at once, and after release the pin stays released for a fixed number of edges. This stops stale pipeline contents from raising a false error.

Top module: `cmd_parity_checker`

## Requirements
- R1: When the 22 bus bits sampled at edge N and `par_in` sampled at edge N+1 hold an odd number of ones in total, and the command at edge N was valid, an error is detected.
- R2: When that total is even, no error is detected and the pin is not driven because of that command.
- R3: A command is valid when any bit of `cs_n` is 0 at edge N. If all four bits are 1, that command starts no report, and the pin's current state continues without interruption.
- R4: A detected error drives the pin from the edge N+2 onward. `err_drive_en` first reads 1, and `err_pin_n` first reads 0, in the cycle after edge N+2.
- R5: A single error keeps the pin driven for exactly two cycles, after edges N+2 and N+3, and releases it after edge N+4.
- R6: An error detected while a hold is running reloads the hold to two cycles, counted from that error's own driving edge.
- R7: While `rst_n` is 0, `err_drive_en` is 0 and `err_pin_n` is 1. This holds from the moment reset asserts, with no clock edge needed.
- R8: After `rst_n` rises, the pin is not driven after the first three clock edges. An error whose data was sampled at the first edge after release is never reported.
- R9: `err_pin_n` is always the inverse of `err_drive_en`: 0 while driven, 1 while released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_bus | input | 22 | Address/command bits protected by parity |
| cs_n | input | 4 | Active-low chip selects that qualify a command |
| par_in | input | 1 | Parity bit for the bus sampled one edge earlier |
| err_drive_en | output | 1 | Pull-down enable of the open-drain error pin |
| err_pin_n | output | 1 | Resolved error pin level, low when an error is flagged |

## Verification
Bus data and chip selects sampled at edge N pair with the parity bit sampled at edge N+1. The pin is driven from edge N+2 and released after edge N+4, unless a later error reloads the hold. Reset effects are immediate, and the masking window covers edges one to three after release. The bench keeps a behavioural model that is advanced once per edge. It compares both outputs at the following falling edge, so every expected value is checked in the exact cycle it is due.

// File: rtl/cmd_parity_checker.sv
module cmd_parity_checker #(
  parameter int DATA_W    = 22,
  parameter int CS_W      = 4,
  parameter int HOLD_CYC  = 2,
  parameter int QUIET_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cmd_bus,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              par_in,
  output logic              err_drive_en,
  output logic              err_pin_n
);

  localparam int HOLD_W  = $clog2(HOLD_CYC + 1);
  localparam int QUIET_W = $clog2(QUIET_CYC + 1);

  logic               stg_par;
  logic               stg_vld;
  logic               det_q;
  logic [HOLD_W-1:0]  hold_cnt;
  logic [QUIET_W-1:0] quiet_cnt;

  wire cmd_valid  = ~&cs_n;
  wire bus_par    = ^cmd_bus;
  wire mismatch   = stg_vld & (stg_par ^ par_in);
  wire quiet_done = (quiet_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_par <= 1'b0;
      stg_vld <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      stg_par <= bus_par;
      stg_vld <= cmd_valid;
      det_q   <= mismatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_cnt <= QUIET_W'(QUIET_CYC);
    else if (!quiet_done)
      quiet_cnt <= quiet_cnt - QUIET_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (det_q && quiet_done)
      hold_cnt <= HOLD_W'(HOLD_CYC);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - HOLD_W'(1);
  end

  assign err_drive_en = (hold_cnt != '0);
  assign err_pin_n    = ~err_drive_en;

endmodule

// File: rtl/cmd_parity_checker_sva.sv
module cmd_parity_checker_sva #(
  parameter int DATA_W    = 22,
  parameter int CS_W      = 4,
  parameter int QUIET_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cmd_bus,
  input logic [CS_W-1:0]   cs_n,
  input logic              par_in,
  input logic              err_drive_en
);

  localparam int CNT_W = $clog2(QUIET_CYC + 3) + 1;
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(QUIET_CYC + 2);

  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_rst <= '0;
    else if (since_rst != CNT_CAP)
      since_rst <= since_rst + CNT_W'(1);
  end

  assert_odd_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= CNT_W'(QUIET_CYC - 1)) && (~&$past(cs_n)) && ((^$past(cmd_bus)) ^ par_in)
    |=> ##1 err_drive_en);

  assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_drive_en) |-> (~&$past(cs_n, 3)) && ((^$past(cmd_bus, 3)) ^ $past(par_in, 2)));

  assert_hold_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_drive_en) |=> err_drive_en);

  assert_reset_release_R7: assert property (@(posedge clk)
    !rst_n |-> !err_drive_en);

  assert_quiet_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CNT_W'(QUIET_CYC)) |-> !err_drive_en);

endmodule

bind cmd_parity_checker cmd_parity_checker_sva #(
  .DATA_W(DATA_W), .CS_W(CS_W), .QUIET_CYC(QUIET_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_bus(cmd_bus), .cs_n(cs_n),
  .par_in(par_in), .err_drive_en(err_drive_en)
);

// File: tb/cmd_parity_checker_tb_top.sv
`timescale 1ns/1ps
module cmd_parity_checker_tb_top;

  localparam real HALF = 2.5;
  localparam int  QUIET = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] cmd_bus;
  logic [3:0]  cs_n;
  logic        par_in;
  logic        err_drive_en;
  logic        err_pin_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int edges_m;
  int hold_m;
  bit det_m, vld_m, par_m;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #HALF clk = ~clk;

  cmd_parity_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_bus(cmd_bus), .cs_n(cs_n),
    .par_in(par_in), .err_drive_en(err_drive_en), .err_pin_n(err_pin_n)
  );

  function automatic bit odd_ones(input logic [21:0] d);
    int n = 0;
    for (int i = 0; i < 22; i++) if (d[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    edges_m = 0; hold_m = 0; det_m = 0; vld_m = 0; par_m = 0;
  endtask

  task automatic step(input logic [21:0] d, input logic [3:0] cs, input logic p, input string tag);
    bit load;
    cmd_bus = d; cs_n = cs; par_in = p;
    @(posedge clk);
    @(negedge clk);
    edges_m++;
    load   = det_m && (edges_m > QUIET);
    hold_m = load ? 2 : (hold_m > 0 ? hold_m - 1 : 0);
    det_m  = vld_m && (par_m ^ p);
    vld_m  = (cs != 4'hF);
    par_m  = odd_ones(d);
    check(err_drive_en, hold_m > 0, tag);
    check(err_pin_n, !(hold_m > 0), "R9");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_bus = '0; cs_n = 4'hF; par_in = 1'b0;
    #1;
    check(err_drive_en, 1'b0, "R7");
    check(err_pin_n, 1'b1, "R7");
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [21:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr[21:0];
  endfunction

  initial begin
    logic [21:0] prev_d;
    logic [21:0] d;
    logic [3:0]  cs;
    bit          prev_good;
    rst_n = 1'b0;
    cmd_bus = '0; cs_n = 4'hF; par_in = 1'b0;
    @(negedge clk);
    do_reset();

    // R8: error on data at the first edge after release is never reported
    step(22'h000001, 4'b1110, 1'b0, "R8");
    step(22'h000000, 4'hF, 1'b0, "R8");
    step(22'h000000, 4'hF, 1'b0, "R8");
    repeat (3) step(22'h0, 4'hF, 1'b0, "R8");

    // R1/R4/R5: single error, valid on each chip select in turn
    for (int k = 0; k < 4; k++) begin
      d = 22'h2A5A5 ^ 22'(k);
      step(d, ~(4'b1 << k), 1'b0, "R1");
      step(22'h0, 4'hF, !odd_ones(d), "R4");
      repeat (4) step(22'h0, 4'hF, 1'b0, "R5");
    end

    // R2: correct parity never flags
    for (int k = 0; k < 8; k++) begin
      d = next_rand();
      step(d, 4'b0000, 1'b0, "R2");
      step(22'h0, 4'b0101, odd_ones(d), "R2");
    end
    repeat (3) step(22'h0, 4'hF, 1'b0, "R2");

    // R3: bad parity with all chip selects high is ignored
    for (int k = 0; k < 4; k++) begin
      d = next_rand() | 22'h1;
      step(d, 4'hF, 1'b0, "R3");
      step(22'h0, 4'hF, !odd_ones(d), "R3");
    end
    repeat (3) step(22'h0, 4'hF, 1'b0, "R3");

    // R6: back-to-back errors extend the hold
    step(22'h000003, 4'b0111, 1'b0, "R6");
    step(22'h000007, 4'b1011, 1'b1, "R6");
    step(22'h000000, 4'b1101, 1'b0, "R6");
    repeat (5) step(22'h0, 4'hF, 1'b0, "R6");

    // R3: invalid cycle during a hold does not cut it short
    step(22'h000010, 4'b1110, 1'b0, "R3");
    step(22'h3FFFFF, 4'hF, 1'b0, "R3");
    repeat (4) step(22'h0, 4'hF, 1'b1, "R3");

    // R7: reset while flagged releases the pin at once
    step(22'h000100, 4'b1110, 1'b0, "R7");
    step(22'h0, 4'hF, 1'b0, "R7");
    step(22'h0, 4'hF, 1'b0, "R7");
    #1;
    do_reset();
    // R8: second release, error sampled at second edge is reported
    step(22'h0, 4'hF, 1'b0, "R8");
    step(22'h000001, 4'b1110, 1'b0, "R8");
    step(22'h0, 4'hF, 1'b0, "R8");
    repeat (5) step(22'h0, 4'hF, 1'b0, "R8");

    // mixed random traffic
    prev_good = 1'b0;
    for (int k = 0; k < 400; k++) begin
      logic [21:0] r;
      r  = next_rand();
      d  = r;
      cs = lfsr[25:22];
      step(d, cs, (lfsr[28:26] == 3'b000) ? !prev_good : prev_good, "R1");
      prev_good = odd_ones(d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule